// File: doc/BRIEF.md
# Latency-Tolerant Stream Write Source

This block feeds write beats to a downstream stream port that will not accept gaps from its source. It reads the beats from a synchronous memory whose data returns a fixed number of cycles after the read is issued. A start command gives a base address and a beat count. The block then issues memory reads ahead of consumption and parks the returned words in a small set of holding registers. It presents them in address order on a valid/ready output port that carries start-of-frame and end-of-frame markers.

The consumer may withdraw its ready at any beat and for any length of time. The block issues a read only when a holding slot is certain to be free when the data returns. Every read in flight therefore has somewhere to land. When the consumer resumes, the next sequential word is already on the output. Once the first beat is shown, output valid stays high until the end-of-frame beat is accepted.

Top module: `sws_stream_source`

## Requirements
- R1: After reset, cmd_ready is 1, out_valid is 0 and mem_rd_en is 0.
- R2: A command is accepted in a cycle where cmd_valid and cmd_ready are both 1. cmd_len holds the beat count minus one. cmd_ready stays 0 from acceptance until the end-of-frame beat is accepted, and cmd_valid is ignored while cmd_ready is 0.
- R3: Beat i of a transfer (i from 0) carries the memory word at address cmd_addr + i, taken modulo 2^AW.
- R4: Once out_valid rises in a transfer, it stays 1 in every cycle until the beat with out_eof = 1 is accepted.
- R5: While out_valid is 1 and out_ready is 0, out_data, out_sof and out_eof stay unchanged in the next cycle.
- R6: out_sof is 1 only on beat 0 and out_eof is 1 only on the last beat. A one-beat transfer (cmd_len = 0) carries both on its single beat.
- R7: Reads are issued only while a transfer is active. Their addresses run cmd_addr, cmd_addr+1, … in order, and exactly cmd_len+1 reads are issued per transfer.
- R8: out_valid first rises in the (LAT+2)-th cycle after the accepting clock edge. With out_ready held at 1, the last beat is accepted cmd_len cycles after the first.
- R9: The reads issued in a transfer never exceed the beats accepted, including a beat accepted in the same cycle, plus LAT+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | AW | First memory address of the transfer |
| cmd_len | input | LW | Number of beats minus one |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address (registered) |
| mem_rd_data | input | DW | Memory word, valid LAT cycles after mem_rd_en |
| out_data | output | DW | Output beat data |
| out_valid | output | 1 | Source ready: a beat is offered |
| out_sof | output | 1 | First beat of the transfer |
| out_eof | output | 1 | Last beat of the transfer |
| out_ready | input | 1 | Destination ready: the offered beat is taken |

## Verification
The memory model returns each word exactly LAT cycles after the read, as the real memory does. The first beat is therefore due in the (LAT+2)-th cycle after the accepting edge. The bench records the cycle of that edge and checks the cycle in which out_valid first appears against it. With ready held high, end-of-frame must be accepted exactly cmd_len cycles after the first beat. Every other result is judged in the cycle in which it appears on the ports: each beat at its handshake, each read address at its strobe, and hold and continuity against the sample taken one cycle earlier. Inputs change 2 ns after a rising edge and outputs are sampled at the falling edge, so each check sees settled values.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} sws_state_e;
endpackage

// File: rtl/sws_return_track.sv
module sws_return_track #(
  parameter int LAT = 2,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  output logic          arrive,
  output logic [CW-1:0] inflight
);
  generate
    if (LAT == 1) begin : g_single
      logic stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= 1'b0;
        else     stage <= issue;
      end
      assign arrive = stage;
    end else begin : g_chain
      logic [LAT-1:0] stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= '0;
        else     stage <= {stage[LAT-2:0], issue};
      end
      assign arrive = stage[LAT-1];
    end
  endgenerate

  // reads issued and not yet written into the holding registers
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(issue) - CW'(arrive);
  end
endmodule

// File: rtl/sws_hold_fifo.sv
module sws_hold_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 3,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head = slot[rp];
endmodule

// File: rtl/sws_issue.sv
module sws_issue #(
  parameter int AW    = 16,
  parameter int LW    = 12,
  parameter int CW    = 2,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic          pop,
  input  logic [CW-1:0] hold_count,
  input  logic [CW-1:0] inflight,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);
  logic [LW:0] left;
  logic [CW:0] occ, limit;

  // slots committed (held + in flight) must stay within DEPTH after this read
  always_comb begin
    occ   = {1'b0, hold_count} + {1'b0, inflight};
    limit = (CW+1)'(DEPTH) + {{CW{1'b0}}, pop};
    rd_en = (left != '0) && (occ < limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left    <= '0;
      rd_addr <= '0;
    end else if (start) begin
      left    <= {1'b0, start_len} + 1'b1;
      rd_addr <= start_addr;
    end else if (rd_en) begin
      left    <= left - 1'b1;
      rd_addr <= rd_addr + 1'b1;
    end
  end
endmodule

// File: rtl/sws_stream_source.sv
module sws_stream_source
  import sws_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int LW  = 12,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eof,
  input  logic          out_ready
);
  localparam int DEPTH = LAT + 1;
  localparam int CW    = $clog2(DEPTH + 1);

  sws_state_e    state;
  logic          accept, pop, arrive, first_q;
  logic [LW-1:0] beats_left;
  logic [CW-1:0] hold_count, inflight;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign out_valid = (state == ST_RUN) && (hold_count != '0);
  assign pop       = out_valid && out_ready;
  assign out_sof   = out_valid && first_q;
  assign out_eof   = out_valid && (beats_left == '0);

  sws_issue #(.AW(AW), .LW(LW), .CW(CW), .DEPTH(DEPTH)) u_issue (
    .clk(clk), .rst(rst), .start(accept), .start_addr(cmd_addr),
    .start_len(cmd_len), .pop(pop), .hold_count(hold_count),
    .inflight(inflight), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr)
  );

  sws_return_track #(.LAT(LAT), .CW(CW)) u_track (
    .clk(clk), .rst(rst), .issue(mem_rd_en), .arrive(arrive),
    .inflight(inflight)
  );

  sws_hold_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_hold (
    .clk(clk), .rst(rst), .push(arrive), .push_data(mem_rd_data),
    .pop(pop), .head(out_data), .count(hold_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      beats_left <= '0;
      first_q    <= 1'b0;
    end else if (accept) begin
      state      <= ST_RUN;
      beats_left <= cmd_len;
      first_q    <= 1'b1;
    end else if (pop) begin
      first_q <= 1'b0;
      if (beats_left == '0) state <= ST_IDLE;
      else                  beats_left <= beats_left - 1'b1;
    end
  end
endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
  parameter int DW    = 32,
  parameter int CW    = 2,
  parameter int DEPTH = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          mem_rd_en,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_eof,
  input logic          out_ready,
  input logic [CW-1:0] hold_count,
  input logic [CW-1:0] inflight
);
  a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eof |=> out_valid);

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                 && $stable(out_sof) && $stable(out_eof));

  a_r6_sof_once: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_sof && !out_eof |=> !out_sof);

  a_r7_no_idle_read: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mem_rd_en);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cmd_ready);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, hold_count} + {1'b0, inflight}) <= (CW+1)'(DEPTH));
endmodule

bind sws_stream_source sws_checker #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .mem_rd_en(mem_rd_en),
  .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
  .out_eof(out_eof), .out_ready(out_ready), .hold_count(hold_count),
  .inflight(inflight)
);

// File: tb/tb_sws_stream_source.sv
`timescale 1ns/1ps
module tb_sws_stream_source;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int LW  = 6;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic [DW-1:0] out_data;
  logic          out_valid, out_sof, out_eof;
  logic          out_ready = 1'b0;

  always #5 clk = ~clk;

  sws_stream_source #(.AW(AW), .DW(DW), .LW(LW), .LAT(LAT)) dut (.*);

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h3C, a + 8'd17};
  endfunction

  // memory model: word returns LAT cycles after the read
  logic [DW-1:0] mp [LAT];
  always_ff @(posedge clk) begin
    mp[0] <= word_at(mem_rd_addr);
    for (int i = 1; i < LAT; i++) mp[i] <= mp[i-1];
  end
  assign mem_rd_data = mp[LAT-1];

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor state
  logic [AW-1:0] exp_base;
  int exp_len, idx, reads, pops, accept_cyc, first_cyc, cur_mode;
  bit active_x = 0, seen_valid = 0, done_flag = 0;
  logic prev_valid = 0, prev_ready = 0;
  logic [DW-1:0] prev_data;
  logic prev_sof, prev_eof;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) begin
        chk(active_x, "R7 read while idle", 1, 0);
        chk(mem_rd_addr == exp_base + AW'(reads), "R7 read address", mem_rd_addr, exp_base + AW'(reads));
        reads++;
        chk(reads <= pops + int'(out_valid && out_ready) + LAT + 1, "R9 reads ahead", reads, pops + LAT + 1);
      end
      if (active_x && !seen_valid && out_valid) begin
        seen_valid = 1;
        first_cyc = cyc;
        chk(cyc - accept_cyc == LAT + 1, "R8 first beat latency", cyc - accept_cyc, LAT + 1);
      end
      if (active_x && seen_valid && prev_valid)
        chk(out_valid, "R4 valid held", out_valid, 1);
      if (prev_valid && !prev_ready && out_valid) begin
        chk(out_data == prev_data, "R5 data held in stall", out_data, prev_data);
        chk(out_sof == prev_sof && out_eof == prev_eof, "R5 markers held", {out_sof, out_eof}, {prev_sof, prev_eof});
      end
      if (out_valid && out_ready) begin
        chk(active_x, "R2 beat outside transfer", 0, 1);
        chk(out_data == word_at(exp_base + AW'(idx)), "R3 beat data", out_data, word_at(exp_base + AW'(idx)));
        chk(out_sof == (idx == 0), "R6 sof", out_sof, idx == 0);
        chk(out_eof == (idx == exp_len), "R6 eof", out_eof, idx == exp_len);
        pops++;
        if (idx == exp_len) begin
          if (cur_mode == 0) chk(cyc - first_cyc == exp_len, "R8 back-to-back beats", cyc - first_cyc, exp_len);
          active_x = 0;
          done_flag = 1;
        end
        idx++;
      end
      if (cmd_valid && cmd_ready) begin
        exp_base = cmd_addr; exp_len = int'(cmd_len);
        idx = 0; reads = 0; pops = 0;
        active_x = 1; seen_valid = 0; done_flag = 0;
        accept_cyc = cyc + 1;
      end
    end
    prev_valid = out_valid; prev_ready = out_ready;
    prev_data = out_data; prev_sof = out_sof; prev_eof = out_eof;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic run_xfer(input logic [AW-1:0] a, input int len, input int mode);
    int k = 0;
    while (!cmd_ready) tick();
    cur_mode = mode;
    out_ready = (mode == 0) || (mode == 1);
    cmd_valid = 1; cmd_addr = a; cmd_len = LW'(len);
    tick();
    cmd_valid = 0;
    while (!done_flag) begin
      case (mode)
        0: out_ready = 1;
        1: out_ready = $urandom % 2;
        2: out_ready = !((k < 12) || (k >= 18 && k < 30));
        3: out_ready = ($urandom % 5) == 0;
        default: begin
          out_ready = $urandom % 2;
          if (k == 5) begin
            chk(!cmd_ready, "R2 busy cmd_ready", cmd_ready, 0);
            cmd_valid = 1; cmd_addr = a ^ 8'h80; cmd_len = LW'(3);
          end else cmd_valid = 0;
        end
      endcase
      tick();
      k++;
      if (cyc > 100000) break;
    end
    cmd_valid = 0;
    out_ready = 0;
    tick();
    chk(reads == len + 1, "R7 read count", reads, len + 1);
    chk(cmd_ready, "R2 ready after eof", cmd_ready, 1);
    chk(!out_valid, "R4 idle after eof", out_valid, 0);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250117));
    repeat (4) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    chk(cmd_ready, "R1 reset cmd_ready", cmd_ready, 1);
    chk(!out_valid, "R1 reset out_valid", out_valid, 0);
    chk(!mem_rd_en, "R1 reset mem_rd_en", mem_rd_en, 0);
    tick();
    run_xfer(8'h10, 0, 0);   // R6 single beat
    run_xfer(8'h20, 0, 3);   // single beat, stalled
    run_xfer(8'hFC, 7, 0);   // R3 address wrap
    run_xfer(8'h40, 20, 2);  // R5 long stalls with reads in flight
    run_xfer(8'h60, 15, 4);  // R2 command while busy
    run_xfer(8'h00, 63, 0);  // longest transfer
    for (int t = 0; t < 24; t++)
      run_xfer(AW'($urandom), int'($urandom % 40), int'($urandom % 5));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule